// File: doc/BRIEF.md
# Split-Screen Line Address Generator

This block works out, line by line, the memory word address at which the display fetch for the current panel line begins. The panel is split horizontally into two regions. The top region shows an image whose first line sits at one base word address. The bottom region shows a second image with its own base address. The row at which the split falls is programmable. Within each region, successive lines are a fixed stride apart. The stride is the visible line width in words at the selected pixel depth plus a signed-free pitch-adjust term, so a line can be narrower than the image stored in memory.

A frame-start strobe captures all configuration inputs and points the generator at line 0 of the top image. Each line-advance strobe then moves to the next line. Once the last panel line is reached, further advances are ignored until the next frame start. The address and the region flag are registered outputs. They feed a pixel fetch engine that is outside this block.

Top module: `split_line_addr`

## Requirements
- R1: After reset `line_addr` is 0 and `lower_region` is 0, and `line_adv` pulses have no effect until the first `frame_start`.
- R2: In the cycle after `frame_start`, `line_addr` equals `base_top` and `lower_region` is 0 (the current line is line 0).
- R3: The line stride in words is floor((`h_size`+1) × 2^`depth` / 2) + `pitch_adj`, where `depth` codes 0, 1, 2, 3 select 1, 2, 4 and 8 bits per pixel and the panel is 8 × (`h_size`+1) pixels wide.
- R4: Line n for n = 0 .. `split_last` is fetched from `base_top` + n × stride, with `lower_region` = 0.
- R5: Line n for n = `split_last`+1 .. `v_last` is fetched from `base_bot` + (n − `split_last` − 1) × stride, with `lower_region` = 1. Once set, `lower_region` stays set until the next `frame_start`.
- R6: The panel holds `v_last`+1 lines. A `line_adv` while on line `v_last` changes neither output.
- R7: When `split_last` ≥ `v_last`, the bottom image is never shown and `lower_region` stays 0 for the whole frame.
- R8: All configuration inputs are sampled only on `frame_start`. Changing them during a frame has no effect until the next `frame_start`.
- R9: Addresses are 16-bit word addresses and wrap modulo 2^16.
- R10: When `frame_start` and `line_adv` are asserted in the same cycle, `frame_start` wins and the result is line 0.
- R11: The outputs change only in the cycle after a `frame_start` or an accepted `line_adv`. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start of frame; captures configuration and selects line 0 |
| line_adv | input | 1 | Advance to the next panel line |
| base_top | input | 16 | First word address of the top image |
| base_bot | input | 16 | First word address of the bottom image |
| split_last | input | 10 | Index of the last line drawn from the top image |
| v_last | input | 10 | Panel height in lines minus one |
| h_size | input | 8 | Panel width in units of 8 pixels, minus one |
| depth | input | 2 | Pixel depth code (0..3 = 1, 2, 4, 8 bits per pixel) |
| pitch_adj | input | 8 | Extra words added to each line stride |
| line_addr | output | 16 | Start word address of the current line |
| lower_region | output | 1 | 1 while the current line belongs to the bottom image |

## Verification
Both outputs come straight from registers. Their new values therefore appear exactly one clock edge after the strobe that causes them, and never later. The bench drives each strobe for one cycle from a falling edge. It compares `line_addr` and `lower_region` at the following falling edge, which is half a period after the updating edge, against an arithmetic model of the line index. On some lines it also waits an extra idle cycle and checks again, to confirm that nothing moves without a strobe.

// File: rtl/sla_pkg.sv
package sla_pkg;

   // Action the sequencer requests from the address register each cycle
   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_LOAD1 = 2'd1,
      CMD_STEP  = 2'd2,
      CMD_LOAD2 = 2'd3
   } addr_cmd_e;

   localparam int unsigned DEPTH_CODES = 4;

endpackage

// File: rtl/sla_stride.sv
module sla_stride #(
   parameter int unsigned AW = 16,
   parameter int unsigned HW = 8,
   parameter int unsigned PW = 8
) (
   input  logic [HW-1:0] h_size,
   input  logic [1:0]    depth,
   input  logic [PW-1:0] pitch_adj,
   output logic [AW-1:0] stride
);
   import sla_pkg::*;

   // Column groups of 8 pixels; widened so the shift by 3 cannot overflow
   localparam int unsigned SW = HW + 4;

   logic [SW-1:0] groups;
   logic [AW-1:0] opt [DEPTH_CODES];

   assign groups = SW'(h_size) + SW'(1);

   // One candidate per pixel depth: 8*groups*bpp/16 = (groups << d) >> 1
   for (genvar d = 0; d < DEPTH_CODES; d++) begin : g_depth
      logic [SW-1:0] scaled;
      assign scaled = (groups << d) >> 1;
      assign opt[d] = AW'(scaled);
   end

   assign stride = opt[depth] + AW'(pitch_adj);

endmodule

// File: rtl/sla_line_seq.sv
module sla_line_seq #(
   parameter int unsigned VW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_adv,
   input  logic [VW-1:0]     split_in,
   input  logic [VW-1:0]     last_in,
   output sla_pkg::addr_cmd_e cmd,
   output logic              lower
);
   import sla_pkg::*;

   logic [VW-1:0] line_q;
   logic [VW-1:0] split_q;
   logic [VW-1:0] last_q;
   logic          lower_q;
   logic          idle_q;   // set from reset until the first frame start

   always_comb begin
      cmd = CMD_NONE;
      if (frame_start) begin
         cmd = CMD_LOAD1;
      end else if (line_adv && !idle_q && (line_q != last_q)) begin
         if (!lower_q && (line_q == split_q)) cmd = CMD_LOAD2;
         else                                 cmd = CMD_STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         split_q <= '0;
         last_q  <= '0;
         lower_q <= 1'b0;
         idle_q  <= 1'b1;
      end else begin
         unique case (cmd)
            CMD_LOAD1: begin
               line_q  <= '0;
               split_q <= split_in;
               last_q  <= last_in;
               lower_q <= 1'b0;
               idle_q  <= 1'b0;
            end
            CMD_STEP:  line_q <= line_q + 1'b1;
            CMD_LOAD2: begin
               line_q  <= line_q + 1'b1;
               lower_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign lower = lower_q;

endmodule

// File: rtl/sla_addr_reg.sv
module sla_addr_reg #(
   parameter int unsigned AW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sla_pkg::addr_cmd_e cmd,
   input  logic [AW-1:0]      base1,
   input  logic [AW-1:0]      base2_in,
   input  logic [AW-1:0]      stride_in,
   output logic [AW-1:0]      addr
);
   import sla_pkg::*;

   logic [AW-1:0] addr_q;
   logic [AW-1:0] base2_q;
   logic [AW-1:0] stride_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         base2_q  <= '0;
         stride_q <= '0;
      end else begin
         unique case (cmd)
            CMD_LOAD1: begin
               addr_q   <= base1;
               base2_q  <= base2_in;
               stride_q <= stride_in;
            end
            CMD_STEP:  addr_q <= addr_q + stride_q;
            CMD_LOAD2: addr_q <= base2_q;
            default: ;
         endcase
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/split_line_addr.sv
module split_line_addr #(
   parameter int unsigned AW = 16,
   parameter int unsigned VW = 10,
   parameter int unsigned HW = 8,
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          line_adv,
   input  logic [AW-1:0] base_top,
   input  logic [AW-1:0] base_bot,
   input  logic [VW-1:0] split_last,
   input  logic [VW-1:0] v_last,
   input  logic [HW-1:0] h_size,
   input  logic [1:0]    depth,
   input  logic [PW-1:0] pitch_adj,
   output logic [AW-1:0] line_addr,
   output logic          lower_region
);
   import sla_pkg::*;

   initial begin
      assert (AW >= 8) else $error("split_line_addr: AW too small");
      assert (VW >= 2) else $error("split_line_addr: VW too small");
      assert (HW >= 1 && PW >= 1) else $error("split_line_addr: bad HW/PW");
   end

   addr_cmd_e     cmd;
   logic [AW-1:0] stride;

   sla_stride #(.AW(AW), .HW(HW), .PW(PW)) u_stride (
      .h_size    (h_size),
      .depth     (depth),
      .pitch_adj (pitch_adj),
      .stride    (stride)
   );

   sla_line_seq #(.VW(VW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .line_adv    (line_adv),
      .split_in    (split_last),
      .last_in     (v_last),
      .cmd         (cmd),
      .lower       (lower_region)
   );

   sla_addr_reg #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .base1     (base_top),
      .base2_in  (base_bot),
      .stride_in (stride),
      .addr      (line_addr)
   );

endmodule

// File: rtl/sla_checker.sv
module sla_checker #(
   parameter int unsigned AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_start,
   input logic          line_adv,
   input logic [AW-1:0] base_top,
   input logic [AW-1:0] line_addr,
   input logic          lower_region
);

   // R2 / R10: a frame start loads the top base and clears the region flag
   p_frame_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (line_addr == $past(base_top)) && !lower_region);

   // R10: frame start beats a simultaneous line advance
   p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && line_adv) |=> !lower_region && (line_addr == $past(base_top)));

   // R5: once in the bottom region, stay there until a frame start
   p_region_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lower_region && !frame_start) |=> lower_region);

   // R5: entry into the bottom region only follows a line advance
   p_rise_on_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lower_region) |-> $past(line_adv) && !$past(frame_start));

   // R11: without a strobe the outputs hold
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !line_adv) |=> $stable(line_addr) && $stable(lower_region));

endmodule

bind split_line_addr sla_checker #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_start  (frame_start),
   .line_adv     (line_adv),
   .base_top     (base_top),
   .line_addr    (line_addr),
   .lower_region (lower_region)
);

// File: tb/tb_split_line_addr.sv
module tb_split_line_addr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        line_adv = 1'b0;
   logic [15:0] base_top = '0;
   logic [15:0] base_bot = '0;
   logic [9:0]  split_last = '0;
   logic [9:0]  v_last = '0;
   logic [7:0]  h_size = '0;
   logic [1:0]  depth = '0;
   logic [7:0]  pitch_adj = '0;
   logic [15:0] line_addr;
   logic        lower_region;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state
   int m_b1, m_b2, m_split, m_last, m_stride, m_idx;
   int upper_cnt, lower_cnt;

   always #4 clk = ~clk;   // 125 MHz

   split_line_addr dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
      .base_top(base_top), .base_bot(base_bot), .split_last(split_last),
      .v_last(v_last), .h_size(h_size), .depth(depth), .pitch_adj(pitch_adj),
      .line_addr(line_addr), .lower_region(lower_region)
   );

   task automatic chk(string req, int got_a, int exp_a, int got_l, int exp_l);
      checks++;
      if (got_a != exp_a || got_l != exp_l) begin
         errors++;
         $display("FAIL %s: addr=%h region=%0d expected addr=%h region=%0d",
                  req, got_a[15:0], got_l, exp_a[15:0], exp_l);
      end
   endtask

   function automatic int exp_addr();
      if (m_idx <= m_split) return (m_b1 + m_idx * m_stride) & 16'hFFFF;
      return (m_b2 + (m_idx - m_split - 1) * m_stride) & 16'hFFFF;
   endfunction

   function automatic int exp_lower();
      return (m_idx > m_split) ? 1 : 0;
   endfunction

   // R3 stride model: 8*(h+1) pixels * bpp / 16 bits per word, plus pitch
   function automatic int calc_stride(int h, int d, int p);
      return (((h + 1) * 8 * (1 << d)) / 16 + p) & 16'hFFFF;
   endfunction

   task automatic run_frame(string req, int b1, int b2, int sp, int lst,
                            int h, int d, int p, int n_adv,
                            bit with_adv, bit scramble);
      @(negedge clk);
      base_top = b1[15:0]; base_bot = b2[15:0]; split_last = sp[9:0];
      v_last = lst[9:0]; h_size = h[7:0]; depth = d[1:0]; pitch_adj = p[7:0];
      frame_start = 1'b1; line_adv = with_adv;
      @(negedge clk);
      frame_start = 1'b0; line_adv = 1'b0;
      m_b1 = b1 & 16'hFFFF; m_b2 = b2 & 16'hFFFF; m_split = sp; m_last = lst;
      m_stride = calc_stride(h, d, p); m_idx = 0;
      upper_cnt = 1; lower_cnt = 0;
      chk(with_adv ? "R10 start wins" : "R2 frame load",
          line_addr, m_b1, lower_region, 0);
      if (scramble) begin   // R8: change everything after capture
         base_top = ~b1[15:0]; base_bot = ~b2[15:0]; split_last = 10'd0;
         v_last = 10'd1; h_size = ~h[7:0]; depth = ~d[1:0]; pitch_adj = 8'hFF;
      end
      for (int i = 0; i < n_adv; i++) begin
         line_adv = 1'b1;
         @(negedge clk);
         line_adv = 1'b0;
         if (m_idx != m_last) begin
            m_idx++;
            if (exp_lower() != 0) lower_cnt++; else upper_cnt++;
         end
         chk(scramble ? "R8 sampled regs" :
             (m_idx > m_split ? "R5 bottom line" : "R4 top line"),
             line_addr, exp_addr(), lower_region, exp_lower());
         if (i % 3 == 0) begin
            @(negedge clk);
            chk("R11 hold", line_addr, exp_addr(), lower_region, exp_lower());
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", line_addr, 0, lower_region, 0);
      rst_n = 1'b1;
      base_top = 16'h1234;
      @(negedge clk);
      line_adv = 1'b1;
      @(negedge clk);
      line_adv = 1'b0;
      @(negedge clk);
      chk("R1 adv before frame", line_addr, 0, lower_region, 0);

      // 320x240 example: 40 groups, 4 bpp -> 80 words per line
      run_frame("R4", 16'h0100, 16'h8000, 'hCE, 239, 39, 2, 0, 242, 0, 0);
      checks++;
      if (upper_cnt != 207 || lower_cnt != 33) begin
         errors++;
         $display("FAIL R6 region split: upper=%0d lower=%0d expected 207/33",
                  upper_cnt, lower_cnt);
      end
      // R6: advances past the last line were part of the frame above (242 > 239)

      // R3: sweep all depth codes, odd and even widths, with pitch adjust
      for (int d = 0; d < 4; d++) begin
         for (int h = 4; h <= 5; h++) begin
            run_frame("R3", 16'h0040 * (d + 1), 16'h4000 + h, 3, 7, h, d, d * 3, 9, 0, 0);
         end
      end

      // R7: split at and beyond the last line
      run_frame("R7", 16'h0200, 16'hA000, 9, 9, 2, 1, 1, 12, 0, 0);
      run_frame("R7", 16'h0300, 16'hB000, 20, 9, 2, 3, 0, 12, 0, 0);
      // split 0: only line 0 from the top image
      run_frame("R5", 16'h0500, 16'hC000, 0, 5, 1, 2, 2, 7, 0, 0);

      // R9: wrap modulo 2^16
      run_frame("R9", 16'hFFF0, 16'hFFFA, 2, 6, 255, 3, 200, 8, 0, 0);

      // R8: inputs scrambled mid-frame
      run_frame("R8", 16'h0700, 16'h0900, 3, 8, 6, 1, 4, 10, 0, 1);

      // R10: simultaneous frame start and line advance, restart mid-frame
      run_frame("R10", 16'h0A00, 16'h0B00, 2, 6, 3, 2, 0, 3, 0, 0);
      run_frame("R10", 16'h0C00, 16'h0D00, 2, 6, 3, 2, 0, 8, 1, 0);

      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule